// File: doc/BRIEF.md
# Reed-Solomon Symbol Error Applier

This block finishes the correction of a flash page after a Reed-Solomon decoder has found the errors. The decoder works on 12-bit symbols. It hands over up to four symbol locations, each with a 12-bit error pattern. The page sits in a byte-wide, single-port RAM: 2048 data bytes first, then the spare bytes at linear addresses 2048 and up. For each location the block finds the one or two bytes that the symbol covers. It then does a read-modify-write XOR of the matching pattern bits into each byte.

The locations are taken in order. A byte address is three halves of the location, rounded down; call it `b`. An odd location changes bytes `b` and `b+1`. An even, non-zero location changes bytes `b-1` and `b`. Location 0 is a short symbol that covers data byte 0 alone. Location 1365 straddles the data/spare boundary. The block checks each entry just before it applies that entry. An entry that cannot be applied stops the job: entries already applied stay in the page, and no later byte is touched. When the job ends, the block raises a one-cycle `done_o`, together with a fail flag and the number of symbols corrected.

Top module: `ecc_sym_fixer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `busy_o`, `done_o`, `fail_o`, `count_o`, `ram_re_o` and `ram_we_o` are all zero.
- R2: An odd location p (1 to 1363) XORs pattern bits [11:4] into byte ⌊3p/2⌋ and pattern bits [3:0], shifted left by four, into byte ⌊3p/2⌋+1.
- R3: An even location p (2 to 1364) XORs pattern bits [11:8] into the low nibble of byte 3p/2−1 and pattern bits [7:0] into byte 3p/2.
- R4: Location 0 XORs pattern bits [7:0] into byte 0 only. If pattern bits [11:8] at location 0 are non-zero, the job fails.
- R5: Location 1365 XORs pattern bits [11:4] into data byte 2047 and pattern bits [3:0]<<4 into spare byte 0 (address 2048).
- R6: Locations 1366 to 1374 follow the odd/even rules of R2 and R3 into the spare area, where spare byte k is at address 2048+k. Location 1374 is still valid.
- R7: A location above 1374 makes the job fail.
- R8: Entries are applied in index order. When an entry fails, the entries before it stay applied, no further RAM write happens, and `done_o` rises with `fail_o` high and `count_o` zero.
- R9: A job with every entry valid ends with a one-cycle `done_o`, `fail_o` low and `count_o` equal to `num_i`. With `num_i` = 0 the job ends without any RAM access.
- R10: A `num_i` above four fails the job without any RAM write.
- R11: Each byte that is changed is read once and written once. The write goes to the same address two cycles after the read, with the read data XOR the mask. Read and write are never active in the same cycle.
- R12: A `start_i` pulse while `busy_o` is high is ignored: its inputs change no byte and produce no extra `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a job and captures num_i, loc_i and pat_i |
| num_i | input | 3 | Number of entries to apply (0 to 4 are valid) |
| loc_i | input | 44 | Four 11-bit symbol locations; entry i is at bits [11i+10:11i] |
| pat_i | input | 48 | Four 12-bit error patterns; entry i is at bits [12i+11:12i] |
| busy_o | output | 1 | A job is in progress |
| done_o | output | 1 | One-cycle pulse when a job ends |
| fail_o | output | 1 | The job failed; valid together with done_o |
| count_o | output | 3 | Symbols corrected; zero after a failure |
| ram_addr_o | output | 12 | Page RAM byte address |
| ram_re_o | output | 1 | Page RAM read enable; data is returned one cycle later |
| ram_we_o | output | 1 | Page RAM write enable |
| ram_wdata_o | output | 8 | Page RAM write data |
| ram_rdata_i | input | 8 | Page RAM read data |

## Verification
The bench aims at the points where the byte arithmetic can slip:
- odd against even offsets, where a swapped nibble shift would put bits into the wrong half of a byte;
- the short symbol at location 0, in both its valid and its too-wide form;
- the straddling location 1365, where a wrong offset would miss spare byte 0;
- the last valid location, 1374, next to the first invalid one, 1375.

A failure in the third of four entries shows whether a design leaves the first two bytes pairs in place and writes nothing afterwards. A design that checked all entries up front, or carried on after a failure, would leave a different page image. The same location given twice with the same pattern must bring the page back to its starting image, which exposes a read-modify-write that reads stale data. A start pulse sent in mid-job would, if honoured, change bytes or produce an extra done pulse.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_RD,
    ST_MOD,
    ST_WR
  } fix_state_t;

endpackage

// File: rtl/ecc_sym_locate.sv
// Maps one (location, pattern) pair onto the byte operations it needs.
module ecc_sym_locate #(
  parameter int LOC_W   = 11,
  parameter int SYM_W   = 12,
  parameter int ADDR_W  = 12,
  parameter int MAX_LOC = 1374
) (
  input  logic [LOC_W-1:0]  loc_i,
  input  logic [SYM_W-1:0]  pat_i,
  output logic [ADDR_W-1:0] first_addr_o,
  output logic [7:0]        first_mask_o,
  output logic [ADDR_W-1:0] second_addr_o,
  output logic [7:0]        second_mask_o,
  output logic              pair_o,
  output logic              bad_o
);
  import ecc_fix_pkg::*;

  localparam int TRI_W = LOC_W + 2;
  localparam int LO_SH = SYM_W - BYTE_W;        // bits left under the top byte
  localparam int UP_SH = 2 * BYTE_W - SYM_W;    // lift of the tail nibble
  localparam logic [LOC_W-1:0] MAX_LOC_L = LOC_W'(MAX_LOC);

  logic [TRI_W-1:0]  triple;
  logic [ADDR_W-1:0] base;
  logic              is_zero;
  logic              is_odd;
  logic              too_wide;

  always_comb begin
    triple   = {2'b00, loc_i} + {1'b0, loc_i, 1'b0};
    base     = ADDR_W'(triple >> 1);
    is_zero  = (loc_i == '0);
    is_odd   = loc_i[0];
    too_wide = |(pat_i >> BYTE_W);
  end

  always_comb begin
    bad_o = (loc_i > MAX_LOC_L) || (is_zero && too_wide);
    if (is_zero) begin
      first_addr_o  = '0;
      first_mask_o  = pat_i[BYTE_W-1:0];
      second_addr_o = '0;
      second_mask_o = '0;
      pair_o        = 1'b0;
    end else if (is_odd) begin
      first_addr_o  = base;
      first_mask_o  = BYTE_W'(pat_i >> LO_SH);
      second_addr_o = base + ADDR_W'(1);
      second_mask_o = BYTE_W'(pat_i << UP_SH);
      pair_o        = 1'b1;
    end else begin
      first_addr_o  = base - ADDR_W'(1);
      first_mask_o  = BYTE_W'(pat_i >> BYTE_W);
      second_addr_o = base;
      second_mask_o = pat_i[BYTE_W-1:0];
      pair_o        = 1'b1;
    end
  end

endmodule

// File: rtl/ecc_fix_seq.sv
// Walks the entries in order and runs one read-modify-write per byte.
module ecc_fix_seq #(
  parameter int ADDR_W  = 12,
  parameter int CNT_W   = 3,
  parameter int MAX_ERR = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  num_i,
  input  logic [ADDR_W-1:0] first_addr_i,
  input  logic [7:0]        first_mask_i,
  input  logic [ADDR_W-1:0] second_addr_i,
  input  logic [7:0]        second_mask_i,
  input  logic              pair_i,
  input  logic              bad_i,
  output logic [CNT_W-1:0]  idx_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_re_o,
  output logic              ram_we_o,
  output logic [7:0]        ram_wdata_o,
  input  logic [7:0]        ram_rdata_i
);
  import ecc_fix_pkg::*;

  localparam logic [CNT_W-1:0] MAX_ERR_L = CNT_W'(MAX_ERR);

  fix_state_t       state;
  logic [CNT_W-1:0] num_q;
  logic [7:0]       mask_q;
  logic             half_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      idx_o       <= '0;
      num_q       <= '0;
      mask_q      <= '0;
      half_q      <= 1'b0;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      fail_o      <= 1'b0;
      count_o     <= '0;
      ram_addr_o  <= '0;
      ram_re_o    <= 1'b0;
      ram_we_o    <= 1'b0;
      ram_wdata_o <= '0;
    end else begin
      done_o <= 1'b0;
      fail_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            busy_o <= 1'b1;
            idx_o  <= '0;
            num_q  <= num_i;
            state  <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if ((num_q > MAX_ERR_L) || ((idx_o != num_q) && bad_i)) begin
            busy_o  <= 1'b0;
            done_o  <= 1'b1;
            fail_o  <= 1'b1;
            count_o <= '0;
            state   <= ST_IDLE;
          end else if (idx_o == num_q) begin
            busy_o  <= 1'b0;
            done_o  <= 1'b1;
            count_o <= num_q;
            state   <= ST_IDLE;
          end else begin
            ram_addr_o <= first_addr_i;
            mask_q     <= first_mask_i;
            half_q     <= 1'b0;
            ram_re_o   <= 1'b1;
            state      <= ST_RD;
          end
        end
        ST_RD: begin
          ram_re_o <= 1'b0;
          state    <= ST_MOD;
        end
        ST_MOD: begin
          ram_wdata_o <= ram_rdata_i ^ mask_q;
          ram_we_o    <= 1'b1;
          state       <= ST_WR;
        end
        ST_WR: begin
          ram_we_o <= 1'b0;
          if (!half_q && pair_i) begin
            half_q     <= 1'b1;
            ram_addr_o <= second_addr_i;
            mask_q     <= second_mask_i;
            ram_re_o   <= 1'b1;
            state      <= ST_RD;
          end else begin
            idx_o <= idx_o + CNT_W'(1);
            state <= ST_CHECK;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ecc_sym_fixer.sv
module ecc_sym_fixer #(
  parameter int DATA_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  parameter int MAX_ERR     = 4,
  parameter int LOC_W       = 11,
  parameter int SYM_W       = 12,
  parameter int MAX_LOC     = 1374,
  localparam int PAGE_BYTES = DATA_BYTES + SPARE_BYTES,
  localparam int ADDR_W     = $clog2(PAGE_BYTES),
  localparam int CNT_W      = $clog2(MAX_ERR + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_i,
  input  logic [CNT_W-1:0]         num_i,
  input  logic [MAX_ERR*LOC_W-1:0] loc_i,
  input  logic [MAX_ERR*SYM_W-1:0] pat_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     fail_o,
  output logic [CNT_W-1:0]         count_o,
  output logic [ADDR_W-1:0]        ram_addr_o,
  output logic                     ram_re_o,
  output logic                     ram_we_o,
  output logic [7:0]               ram_wdata_o,
  input  logic [7:0]               ram_rdata_i
);

  logic [MAX_ERR*LOC_W-1:0] loc_q;
  logic [MAX_ERR*SYM_W-1:0] pat_q;
  logic [CNT_W-1:0]         idx;

  logic [ADDR_W-1:0] fa_arr [MAX_ERR];
  logic [7:0]        fm_arr [MAX_ERR];
  logic [ADDR_W-1:0] sa_arr [MAX_ERR];
  logic [7:0]        sm_arr [MAX_ERR];
  logic              pr_arr [MAX_ERR];
  logic              bd_arr [MAX_ERR];

  logic [ADDR_W-1:0] sel_fa, sel_sa;
  logic [7:0]        sel_fm, sel_sm;
  logic              sel_pr, sel_bd;

  // Entry capture; a start while busy leaves the held entries alone.
  always_ff @(posedge clk) begin
    if (rst) begin
      loc_q <= '0;
      pat_q <= '0;
    end else if (start_i && !busy_o) begin
      loc_q <= loc_i;
      pat_q <= pat_i;
    end
  end

  for (genvar g = 0; g < MAX_ERR; g++) begin : g_map
    ecc_sym_locate #(
      .LOC_W  (LOC_W),
      .SYM_W  (SYM_W),
      .ADDR_W (ADDR_W),
      .MAX_LOC(MAX_LOC)
    ) u_map (
      .loc_i        (loc_q[g*LOC_W +: LOC_W]),
      .pat_i        (pat_q[g*SYM_W +: SYM_W]),
      .first_addr_o (fa_arr[g]),
      .first_mask_o (fm_arr[g]),
      .second_addr_o(sa_arr[g]),
      .second_mask_o(sm_arr[g]),
      .pair_o       (pr_arr[g]),
      .bad_o        (bd_arr[g])
    );
  end

  always_comb begin
    sel_fa = '0;
    sel_fm = '0;
    sel_sa = '0;
    sel_sm = '0;
    sel_pr = 1'b0;
    sel_bd = 1'b0;
    for (int i = 0; i < MAX_ERR; i++) begin
      if (idx == CNT_W'(i)) begin
        sel_fa = fa_arr[i];
        sel_fm = fm_arr[i];
        sel_sa = sa_arr[i];
        sel_sm = sm_arr[i];
        sel_pr = pr_arr[i];
        sel_bd = bd_arr[i];
      end
    end
  end

  ecc_fix_seq #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .MAX_ERR(MAX_ERR)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .num_i        (num_i),
    .first_addr_i (sel_fa),
    .first_mask_i (sel_fm),
    .second_addr_i(sel_sa),
    .second_mask_i(sel_sm),
    .pair_i       (sel_pr),
    .bad_i        (sel_bd),
    .idx_o        (idx),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .fail_o       (fail_o),
    .count_o      (count_o),
    .ram_addr_o   (ram_addr_o),
    .ram_re_o     (ram_re_o),
    .ram_we_o     (ram_we_o),
    .ram_wdata_o  (ram_wdata_o),
    .ram_rdata_i  (ram_rdata_i)
  );

endmodule

// File: rtl/ecc_sym_fixer_chk.sv
module ecc_sym_fixer_chk #(
  parameter int ADDR_W     = 12,
  parameter int CNT_W      = 3,
  parameter int PAGE_BYTES = 2112,
  parameter int MAX_ERR    = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              busy_o,
  input logic              done_o,
  input logic              fail_o,
  input logic [CNT_W-1:0]  count_o,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic              ram_re_o,
  input logic              ram_we_o
);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy_o && !done_o && !fail_o && !ram_re_o && !ram_we_o));

  assert_addr_in_page_R6: assert property (@(posedge clk) disable iff (rst)
    (ram_re_o || ram_we_o) |-> (32'(ram_addr_o) < PAGE_BYTES));

  assert_fail_with_done_R8: assert property (@(posedge clk) disable iff (rst)
    fail_o |-> (done_o && count_o == '0));

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (rst)
    (done_o && !fail_o) |-> (32'(count_o) <= MAX_ERR));

  assert_done_ends_busy_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  assert_rw_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(ram_re_o && ram_we_o));

  assert_write_after_read_R11: assert property (@(posedge clk) disable iff (rst)
    ram_we_o |-> ($past(ram_re_o, 2) && $past(ram_addr_o, 2) == ram_addr_o));

  assert_idle_no_ram_R12: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!ram_re_o && !ram_we_o));

endmodule

bind ecc_sym_fixer ecc_sym_fixer_chk #(
  .ADDR_W    (ADDR_W),
  .CNT_W     (CNT_W),
  .PAGE_BYTES(PAGE_BYTES),
  .MAX_ERR   (MAX_ERR)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .fail_o    (fail_o),
  .count_o   (count_o),
  .ram_addr_o(ram_addr_o),
  .ram_re_o  (ram_re_o),
  .ram_we_o  (ram_we_o)
);

// File: tb/tb_ecc_sym_fixer.sv
`timescale 1ns/1ps
module tb_ecc_sym_fixer;
  localparam int PAGE  = 2112;
  localparam int SPARE = 2048;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [2:0]  num_i = '0;
  logic [43:0] loc_i = '0;
  logic [47:0] pat_i = '0;
  logic        busy_o, done_o, fail_o;
  logic [2:0]  count_o;
  logic [11:0] ram_addr_o;
  logic        ram_re_o, ram_we_o;
  logic [7:0]  ram_wdata_o;
  logic [7:0]  ram_rdata_i;

  logic [7:0] mem  [PAGE];
  logic [7:0] gold [PAGE];

  int total = 0;
  int fails = 0;
  int wr_cnt = 0;
  int q_fail[$];
  int q_cnt[$];
  int q_wr[$];
  string q_tag[$];

  always #10 clk = ~clk;

  ecc_sym_fixer dut (
    .clk(clk), .rst(rst), .start_i(start_i), .num_i(num_i),
    .loc_i(loc_i), .pat_i(pat_i), .busy_o(busy_o), .done_o(done_o),
    .fail_o(fail_o), .count_o(count_o), .ram_addr_o(ram_addr_o),
    .ram_re_o(ram_re_o), .ram_we_o(ram_we_o), .ram_wdata_o(ram_wdata_o),
    .ram_rdata_i(ram_rdata_i)
  );

  // Page RAM model: one-cycle read latency, loaded while reset is high.
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PAGE; i++) mem[i] <= 8'(i * 37 + 11);
    end else if (ram_we_o) begin
      mem[ram_addr_o] <= ram_wdata_o;
    end
    if (ram_re_o) ram_rdata_i <= mem[ram_addr_o];
  end

  always @(posedge clk) begin
    if (start_i && !busy_o) wr_cnt <= 0;
    else if (ram_we_o) wr_cnt <= wr_cnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Reference model of one entry, written from the byte-index rules.
  function automatic bit ref_apply(input int p, input int q);
    if (p > 1374) return 1'b0;
    if (p == 0) begin
      if (q > 255) return 1'b0;
      gold[0] ^= 8'(q);
    end else if (p == 1365) begin
      gold[2047]     ^= 8'(q >> 4);
      gold[SPARE + 0] ^= 8'((q << 4) & 255);
    end else if (p > 1365) begin
      if (p % 2 == 1) begin
        gold[SPARE + 3*p/2 - 2048] ^= 8'(q >> 4);
        gold[SPARE + 3*p/2 - 2047] ^= 8'((q << 4) & 255);
      end else begin
        gold[SPARE + 3*p/2 - 2049] ^= 8'(q >> 8);
        gold[SPARE + 3*p/2 - 2048] ^= 8'(q & 255);
      end
    end else if (p % 2 == 1) begin
      gold[3*p/2]     ^= 8'(q >> 4);
      gold[3*p/2 + 1] ^= 8'((q << 4) & 255);
    end else begin
      gold[3*p/2 - 1] ^= 8'(q >> 8);
      gold[3*p/2]     ^= 8'(q & 255);
    end
    return 1'b1;
  endfunction

  // Driver: computes the expected outcome, queues it, and runs the job.
  task automatic run_job(input string tag, input int n, input int lc[4], input int pt[4]);
    int ef = 0;
    int wr = 0;
    if (n > 4) ef = 1;
    else begin
      for (int i = 0; i < n; i++) begin
        if (!ref_apply(lc[i], pt[i])) begin
          ef = 1;
          break;
        end
        wr += (lc[i] == 0) ? 1 : 2;
      end
    end
    q_fail.push_back(ef);
    q_cnt.push_back(ef ? 0 : n);
    q_wr.push_back(wr);
    q_tag.push_back(tag);
    @(negedge clk);
    num_i = 3'(n);
    for (int i = 0; i < 4; i++) begin
      loc_i[i*11 +: 11] = 11'(lc[i]);
      pat_i[i*12 +: 12] = 12'(pt[i]);
    end
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: pops the oldest expectation at each done pulse.
  always @(negedge clk) begin
    if (!rst && done_o) begin
      if (q_tag.size() == 0) begin
        chk(1'b0, "R12 unexpected done", 1, 0);
      end else begin
        int ef, ec, ew, bad, first;
        string tg;
        ef = q_fail.pop_front();
        ec = q_cnt.pop_front();
        ew = q_wr.pop_front();
        tg = q_tag.pop_front();
        chk(int'(fail_o) == ef, {tg, " fail flag"}, int'(fail_o), ef);
        chk(int'(count_o) == ec, {tg, " count"}, int'(count_o), ec);
        chk(wr_cnt == ew, {tg, " R11 byte writes"}, wr_cnt, ew);
        bad = 0;
        first = -1;
        for (int i = 0; i < PAGE; i++) begin
          if (mem[i] !== gold[i]) begin
            bad++;
            if (first < 0) first = i;
          end
        end
        if (bad != 0)
          $display("FAIL %s page: first wrong byte %0d actual %0d expected %0d",
                   tg, first, mem[first], gold[first]);
        total++;
        if (bad != 0) fails++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < PAGE; i++) gold[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !fail_o, "R1 flags in reset", int'(busy_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy_o && !done_o && !fail_o && count_o == 0, "R1 flags after reset", int'(count_o), 0);
    chk(!ram_re_o && !ram_we_o, "R1 RAM idle", int'(ram_we_o), 0);

    run_job("R2 odd", 1, '{1, 0, 0, 0}, '{'hABC, 0, 0, 0});           wait_done();
    run_job("R3 even", 1, '{2, 0, 0, 0}, '{'h5A3, 0, 0, 0});          wait_done();
    run_job("R4 zero ok", 1, '{0, 0, 0, 0}, '{'h0FF, 0, 0, 0});       wait_done();
    run_job("R4 zero wide", 1, '{0, 0, 0, 0}, '{'h100, 0, 0, 0});     wait_done();
    run_job("R5 straddle", 1, '{1365, 0, 0, 0}, '{'hE71, 0, 0, 0});   wait_done();
    run_job("R6 spare", 3, '{1366, 1367, 1374, 0}, '{'h9C4, 'h3B6, 'hF0F, 0}); wait_done();
    run_job("R7 out of range", 1, '{1375, 0, 0, 0}, '{'h001, 0, 0, 0}); wait_done();
    run_job("R8 stop at third", 4, '{3, 10, 1400, 7}, '{'h111, 'h2F2, 'h333, 'h444}); wait_done();
    run_job("R9 none", 0, '{5, 6, 7, 8}, '{'hFFF, 'hFFF, 'hFFF, 'hFFF}); wait_done();
    run_job("R9 four", 4, '{1368, 0, 684, 1001}, '{'hFFF, 'h07F, 'h800, 'h00F}); wait_done();
    run_job("R11 twice", 2, '{9, 9, 0, 0}, '{'h123, 'h123, 0, 0});    wait_done();
    run_job("R10 too many", 5, '{1, 2, 3, 4}, '{1, 2, 3, 4});         wait_done();

    // R12: a second start in mid-job must be ignored.
    run_job("R12 busy start", 2, '{40, 41, 0, 0}, '{'h5E5, 'hA1A, 0, 0});
    @(negedge clk);
    chk(busy_o, "R12 busy during job", int'(busy_o), 1);
    num_i = 3'd1;
    loc_i = 44'(5);
    pat_i = 48'hFFF;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    repeat (20) @(negedge clk);
    chk(q_tag.size() == 0, "R12 pending results", q_tag.size(), 0);
    chk(!busy_o && !ram_we_o, "R12 idle after job", int'(busy_o), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule